// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block moves a small two-channel SDRAM controller into and out of self-refresh. Software sets a single control bit to ask for self-refresh and clears it to ask for the exit. The block captures that bit in a register and runs a fixed command sequence. Both channels follow the sequence in the same cycles. On entry the block issues an auto-refresh, waits a programmable refresh-cycle time, then issues the self-refresh command while pulling every clock-enable low. On exit it raises clock-enable, waits a programmable exit delay, then issues an auto-refresh and waits the refresh-cycle time again before it returns to idle.

The block also screens writes to the memory mode register. A write is accepted only when access, self-refresh, power-down and deep power-down are all off and no channel reports a pending state. Any other write is refused with an error pulse. A low-power standby indication has no influence on the sequence, and clock-enable stays driven while it is asserted.

Top module: `sdram_sref_seq`

## Requirements
- R1: Out of reset, every cke_o bit is 1, all four command lines are 1 (deselect), status_o is all zero, and busy_o, mode_ok_o and mode_err_o are 0.
- R2: The control bit is registered. One cycle after the registered bit is seen set in idle, the block issues an auto-refresh (cs_n, ras_n and cas_n 0, we_n 1) with cke_o high. It then drives t_rfc_i+1 deselect cycles and then issues the self-refresh command, which is the same pattern with cke_o low in that cycle.
- R3: From the self-refresh command until the exit begins, cke_o is 0 on every channel, and all channels always carry the same cke_o value.
- R4: When the registered bit is seen clear in self-refresh, cke_o rises. The block then drives t_xsr_i+1 deselect cycles, issues an auto-refresh, drives t_rfc_i+1 deselect cycles and returns to idle.
- R5: After the self-refresh command the block drives t_rfc_i+1 deselect cycles before it can begin an exit. A timer value of 0 gives exactly one wait cycle.
- R6: A change of the control bit during a sequence does not cut that sequence short. It is acted on once the block reaches self-refresh or idle.
- R7: Each status_o bit is 1 in every state other than idle and 0 in idle.
- R8: busy_o is 1 whenever the registered control bit is set or the block is not idle, so it covers the whole span from the request through the post-exit auto-refresh wait.
- R9: standby_i has no effect on any output or on the sequence. In particular, cke_o stays driven low through standby while the block is in self-refresh.
- R10: A mode_wr_i pulse gives a one-cycle mode_ok_o in the next cycle when access_en_i, the registered control bit, pd_en_i and dpd_en_i are all 0 and status_o is all zero.
- R11: A mode_wr_i pulse under any other condition gives a one-cycle mode_err_o in the next cycle instead of mode_ok_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sref_req_i | input | 1 | Software control bit: 1 asks for self-refresh, 0 asks for exit |
| standby_i | input | 1 | Low-power standby indication (no effect) |
| t_rfc_i | input | TIMER_W | Refresh-cycle wait, in cycles minus one |
| t_xsr_i | input | TIMER_W | Exit delay after clock-enable rises, in cycles minus one |
| mode_wr_i | input | 1 | Mode-register write attempt |
| access_en_i | input | 1 | SDRAM access enable |
| pd_en_i | input | 1 | Power-down enable |
| dpd_en_i | input | 1 | Deep power-down enable |
| cke_o | output | N_CH | Clock enable, one per channel |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| status_o | output | N_CH | Per-channel transition or self-refresh flag |
| busy_o | output | 1 | Request pending or sequence running |
| mode_ok_o | output | 1 | Mode write accepted pulse |
| mode_err_o | output | 1 | Mode write refused pulse |

## Verification
The hardest case to reach is a control-bit change that lands in the middle of a wait. It has to be held back, and then a full entry must still be followed at once by an exit, or a full exit by a re-entry. The stimulus toggles the bit a few cycles after it rises, and again during the post-exit wait. It also uses zero timer values, so that the requests fall on the shortest windows. Mode writes are attempted in idle, inside self-refresh while standby is asserted, and during the exit with the bit already clear, so that the status-pending refusal is exercised on its own.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE_AREF, ST_PRE_WAIT, ST_SRE, ST_SRE_WAIT,
    ST_SELF, ST_XSR, ST_POST_AREF, ST_POST_WAIT
  } sref_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
  parameter int TIMER_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TIMER_W-1:0] load_val_i,
  output logic               done_o
);
  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_timer_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sref_chan.sv
module sref_chan (
  input  logic cke_low_i,
  input  logic active_i,
  output logic cke_o,
  output logic status_o
);
  assign cke_o    = ~cke_low_i;
  assign status_o = active_i;
endmodule

// File: rtl/sref_mode_guard.sv
module sref_mode_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic access_en_i,
  input  logic sref_en_i,
  input  logic pd_en_i,
  input  logic dpd_en_i,
  input  logic status_any_i,
  output logic ok_o,
  output logic err_o
);
  logic allowed;

  assign allowed = !(access_en_i | sref_en_i | pd_en_i | dpd_en_i | status_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ok_o  <= mode_wr_i & allowed;
      err_o <= mode_wr_i & ~allowed;
    end
  end

  assert_ok_has_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $past(mode_wr_i));
  assert_err_needs_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(mode_wr_i) && ($past(status_any_i) || $past(access_en_i) ||
               $past(sref_en_i) || $past(pd_en_i) || $past(dpd_en_i))));
endmodule

// File: rtl/sdram_sref_seq.sv
module sdram_sref_seq #(
  parameter int N_CH    = 2,
  parameter int TIMER_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sref_req_i,
  input  logic               standby_i,
  input  logic [TIMER_W-1:0] t_rfc_i,
  input  logic [TIMER_W-1:0] t_xsr_i,
  input  logic               mode_wr_i,
  input  logic               access_en_i,
  input  logic               pd_en_i,
  input  logic               dpd_en_i,
  output logic [N_CH-1:0]    cke_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [N_CH-1:0]    status_o,
  output logic               busy_o,
  output logic               mode_ok_o,
  output logic               mode_err_o
);
  import sref_pkg::*;

  localparam logic [N_CH-1:0] CKE_ALL = {N_CH{1'b1}};

  sref_state_e        state_q, state_d;
  logic               req_q;
  logic               tmr_load, tmr_done;
  logic [TIMER_W-1:0] tmr_val;
  logic               cke_low, active;
  sd_cmd_t            cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= sref_req_i;
    end
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = t_rfc_i;
    unique case (state_q)
      ST_IDLE:      if (req_q) state_d = ST_PRE_AREF;
      ST_PRE_AREF:  begin tmr_load = 1'b1; state_d = ST_PRE_WAIT; end
      ST_PRE_WAIT:  if (tmr_done) state_d = ST_SRE;
      ST_SRE:       begin tmr_load = 1'b1; state_d = ST_SRE_WAIT; end
      ST_SRE_WAIT:  if (tmr_done) state_d = ST_SELF;
      ST_SELF: if (!req_q) begin
        tmr_load = 1'b1;
        tmr_val  = t_xsr_i;
        state_d  = ST_XSR;
      end
      ST_XSR:       if (tmr_done) state_d = ST_POST_AREF;
      ST_POST_AREF: begin tmr_load = 1'b1; state_d = ST_POST_WAIT; end
      ST_POST_WAIT: if (tmr_done) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  sref_timer #(.TIMER_W(TIMER_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  assign cke_low = (state_q == ST_SRE) || (state_q == ST_SRE_WAIT) || (state_q == ST_SELF);
  assign active  = (state_q != ST_IDLE);
  assign cmd     = (state_q == ST_PRE_AREF || state_q == ST_SRE || state_q == ST_POST_AREF)
                   ? CMD_REF : CMD_DESEL;

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign busy_o  = req_q | active;

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    sref_chan i_chan (
      .cke_low_i (cke_low),
      .active_i  (active),
      .cke_o     (cke_o[g]),
      .status_o  (status_o[g])
    );
  end

  sref_mode_guard i_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .access_en_i  (access_en_i),
    .sref_en_i    (req_q),
    .pd_en_i      (pd_en_i),
    .dpd_en_i     (dpd_en_i),
    .status_any_i (|status_o),
    .ok_o         (mode_ok_o),
    .err_o        (mode_err_o)
  );

  assert_ref_then_desel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o) |=> (cs_n_o && ras_n_o && cas_n_o && we_n_o));
  assert_cke_fall_on_sre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o[0]) |-> (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o));
  assert_cke_uniform_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o == '0) || (cke_o == CKE_ALL));
  assert_cke_low_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o != CKE_ALL) |-> (status_o == CKE_ALL));
  assert_status_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0) |-> busy_o);
  assert_standby_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && state_q == ST_SELF && req_q) |=> (state_q == ST_SELF));
endmodule

// File: tb/test_sdram_sref_seq.sv
module test_sdram_sref_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 2;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sref_req = 0, standby = 0, mode_wr = 0, acc = 0, pd = 0, dpd = 0;
  logic [TW-1:0] t_rfc = 3, t_xsr = 2;
  logic [N_CH-1:0] cke, status;
  logic cs_n, ras_n, cas_n, we_n, busy, ok, err;

  int checks = 0, fails = 0, cycles = 0;

  // reference model: 0 idle,1 pre-ref,2 pre-wait,3 sre,4 sre-wait,5 self,6 xsr,7 post-ref,8 post-wait
  int m_state = 0, m_cnt = 0;
  bit m_req = 0, m_ok = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_sref_seq #(.N_CH(N_CH), .TIMER_W(TW)) i_sdram_sref_seq (
    .clk_i(clk), .rst_ni(rst_n), .sref_req_i(sref_req), .standby_i(standby),
    .t_rfc_i(t_rfc), .t_xsr_i(t_xsr), .mode_wr_i(mode_wr), .access_en_i(acc),
    .pd_en_i(pd), .dpd_en_i(dpd), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .status_o(status), .busy_o(busy),
    .mode_ok_o(ok), .mode_err_o(err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_req = 0; m_ok = 0; m_err = 0;
    end else begin
      bit allow;
      allow = !acc && !m_req && !pd && !dpd && (m_state == 0);
      m_ok  = mode_wr && allow;
      m_err = mode_wr && !allow;
      case (m_state)
        0: if (m_req) m_state = 1;
        1: begin m_cnt = int'(t_rfc); m_state = 2; end
        2: if (m_cnt == 0) m_state = 3; else m_cnt--;
        3: begin m_cnt = int'(t_rfc); m_state = 4; end
        4: if (m_cnt == 0) m_state = 5; else m_cnt--;
        5: if (!m_req) begin m_cnt = int'(t_xsr); m_state = 6; end
        6: if (m_cnt == 0) m_state = 7; else m_cnt--;
        7: begin m_cnt = int'(t_rfc); m_state = 8; end
        8: if (m_cnt == 0) m_state = 0; else m_cnt--;
        default: m_state = 0;
      endcase
      m_req = sref_req;
    end
  end

  task automatic check(input bit cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N_CH-1:0] e_cke, e_st;
      logic [3:0] e_cmd;
      bit is_ref;
      is_ref = (m_state == 1 || m_state == 3 || m_state == 7);
      e_cmd = is_ref ? 4'b0001 : 4'b1111;
      e_cke = (m_state >= 3 && m_state <= 5) ? '0 : '1;
      e_st  = (m_state != 0) ? '1 : '0;
      check(cke == e_cke, "cke R3", int'(cke), int'(e_cke));
      check({cs_n, ras_n, cas_n, we_n} == e_cmd, "cmd R2 R4 R5",
            int'({cs_n, ras_n, cas_n, we_n}), int'(e_cmd));
      check(status == e_st, "status R7", int'(status), int'(e_st));
      check(busy == (m_req || m_state != 0), "busy R8", int'(busy), int'(m_req || m_state != 0));
      check(ok == m_ok, "mode ok R10", int'(ok), int'(m_ok));
      check(err == m_err, "mode err R11", int'(err), int'(m_err));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 50000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(cke == '1 && {cs_n, ras_n, cas_n, we_n} == 4'hF, "reset R1 cke/cmd",
          int'({cke, cs_n, ras_n, cas_n, we_n}), 'h3F);
    check(status == 0 && !busy && !ok && !err, "reset R1 flags",
          int'({status, busy, ok, err}), 0);
    rst_n = 1;
    cyc(2);
    // R10 accepted write
    mode_wr = 1; cyc(1); mode_wr = 0; cyc(2);
    // R11 refusals by each enable
    mode_wr = 1; acc = 1; cyc(1); mode_wr = 0; acc = 0; cyc(1);
    mode_wr = 1; pd = 1;  cyc(1); mode_wr = 0; pd = 0;  cyc(1);
    mode_wr = 1; dpd = 1; cyc(1); mode_wr = 0; dpd = 0; cyc(1);
    // R6 bit dropped mid-entry: entry completes, then exits
    sref_req = 1; cyc(4); sref_req = 0; cyc(35);
    check(cke == '1 && !busy, "R6 back to idle", int'({cke, busy}), 'h6);
    // R9 standby inside self-refresh, mode write refused
    sref_req = 1; cyc(14); standby = 1; cyc(4);
    check(cke == '0, "R9 cke held low in standby", int'(cke), 0);
    mode_wr = 1; cyc(1); mode_wr = 0; cyc(3);
    standby = 0; cyc(2);
    check(cke == '0, "R9 still in self-refresh", int'(cke), 0);
    sref_req = 0; cyc(3);
    // status pending alone blocks (R11)
    mode_wr = 1; cyc(1); mode_wr = 0; cyc(20);
    check(!busy && status == 0, "R4 exit complete", int'({busy, status}), 0);
    // zero timers, re-request during post-exit wait (R5, R6)
    t_rfc = 0; t_xsr = 0;
    sref_req = 1; cyc(8); sref_req = 0; cyc(4); sref_req = 1; cyc(14);
    sref_req = 0; cyc(15);
    t_rfc = 5; t_xsr = 4;
    sref_req = 1; cyc(20); sref_req = 0; cyc(30);
    check(!busy && cke == '1, "R4 final idle", int'({busy, cke}), 'h3);
    mode_wr = 1; cyc(1); mode_wr = 0; cyc(3);
    finish_run();
  end
endmodule